// File: doc/BRIEF.md
# Interrupt Controller with Hidden Non-Maskable Sources

This block gathers interrupt requests from peripherals into one pending vector and drives a single active-high interrupt line to a processor. Peripherals use two bit-vector inputs each cycle. A 1 in the raise vector marks a source pending. A 1 in the drop vector withdraws that source. A 0 in either vector leaves the source as it is.

The processor reaches two 8-bit registers through a small register port made of a select, a write strobe, one address bit and a data byte. One register is a read/write enable mask. The other is the read-only low byte of the pending vector. The pending vector is wider than the visible byte. The sources above bit 7 are held internally, cannot be masked and never appear on the read path, so they act as non-maskable sources. They still drive the interrupt line.

The design has no state machine. Its state is two registers: the pending vector and the enable mask. The interrupt line is a combinational function of these two registers.

Top module: `irq_gather`

## Requirements
- R1: While `rst_n` is low, and after it rises, the enable mask is 0x00, every pending bit (hidden ones included) is 0, and `cpu_irq` is 0.
- R2: On each rising clock edge, every bit set in `raise_vec` becomes pending. Bits that are 0 in both `raise_vec` and `drop_vec` keep their value.
- R3: On each rising clock edge, every bit set in `drop_vec` and clear in `raise_vec` stops being pending.
- R4: When one bit is set in both `raise_vec` and `drop_vec` in the same cycle, the raise wins and the bit is pending after the edge.
- R5: A cycle with `reg_sel`=1, `reg_wr`=1 and `reg_addr`=0 loads `reg_wdata` into the enable mask at the clock edge. Bit n set to 1 enables source n.
- R6: Read data is combinational. With `reg_sel`=1, address 0 returns the enable mask and address 1 returns pending bits 7..0. With `reg_sel`=0 it returns 0x00. A write to address 1 changes neither the mask nor the pending vector.
- R7: `cpu_irq` is 1 exactly when some pending bit 0..7 has its enable bit set, or any pending bit 8..11 is set. It drops to 0 in the cycle after the last such request is withdrawn.
- R8: Pending bits 8..11 raise `cpu_irq` even when the enable mask is 0x00. They never show in the pending read, which reads 0 in their positions.
- R9: A visible source that is pending while masked stays pending. `cpu_irq` rises in the same cycle that the mask write enabling it takes effect.
- R10: With `reg_sel`=0, `reg_wr` has no effect on the enable mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| raise_vec | input | 12 | Per-source request set strobes |
| drop_vec | input | 12 | Per-source request clear strobes |
| reg_sel | input | 1 | Register port select |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = enable mask, 1 = pending byte |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| cpu_irq | output | 1 | Interrupt line to the processor, active high |

## Verification
A wrong pending bit among the low eight shows on the pending read in the cycle after the edge that corrupted it. A wrong hidden bit shows only on `cpu_irq`, and only while every visible request is withdrawn or masked, so the bench clears the visible sources before it judges the hidden ones. A corrupted mask bit shows on the mask read after the next edge. It shows on `cpu_irq` only when the matching source is pending, which is why the vectors pair mask changes with pending patterns that differ in exactly the bits being masked.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
    localparam int SRC_W = 12;
    localparam int VIS_W = 8;

    typedef enum logic {
        SEL_MASK    = 1'b0,
        SEL_PENDING = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/irq_pending_reg.sv
module irq_pending_reg #(
    parameter int SRC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] raise_vec,
    input  logic [SRC_W-1:0] drop_vec,
    output logic [SRC_W-1:0] pend_q
);
    logic [SRC_W-1:0] pend_d;

    // A raise overrides a drop on the same bit.
    always_comb begin
        pend_d = (pend_q & ~drop_vec) | raise_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assert_raise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_vec != '0) |=> ((pend_q & $past(raise_vec)) == $past(raise_vec)));

    assert_raise_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((raise_vec & drop_vec) != '0) |=> ((pend_q & $past(raise_vec & drop_vec)) != '0));

    assert_drop_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((drop_vec & ~raise_vec) != '0) |=> ((pend_q & $past(drop_vec & ~raise_vec)) == '0));

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((raise_vec == '0) && (drop_vec == '0)) |=> $stable(pend_q));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int VIS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [VIS_W-1:0] reg_wdata,
    output logic [VIS_W-1:0] en_q
);
    import irq_gather_pkg::*;

    logic mask_we;

    always_comb begin
        mask_we = reg_sel && reg_wr && (reg_sel_e'(reg_addr) == SEL_MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (mask_we) begin
            en_q <= reg_wdata;
        end
    end

    assert_mask_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && !reg_addr) |=> (en_q == $past(reg_wdata)));

    assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_sel && reg_wr && !reg_addr) |=> $stable(en_q));
endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen #(
    parameter int SRC_W = 12,
    parameter int VIS_W = 8
) (
    input  logic [SRC_W-1:0] pend_q,
    input  logic [VIS_W-1:0] en_q,
    output logic             cpu_irq
);
    logic [SRC_W-1:0] live;

    for (genvar i = 0; i < SRC_W; i++) begin : g_src
        if (i < VIS_W) begin : g_maskable
            assign live[i] = pend_q[i] & en_q[i];
        end else begin : g_hidden
            assign live[i] = pend_q[i];
        end
    end

    assign cpu_irq = |live;
endmodule

// File: rtl/irq_gather.sv
module irq_gather #(
    parameter int SRC_W = irq_gather_pkg::SRC_W,
    parameter int VIS_W = irq_gather_pkg::VIS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] raise_vec,
    input  logic [SRC_W-1:0] drop_vec,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [VIS_W-1:0] reg_wdata,
    output logic [VIS_W-1:0] reg_rdata,
    output logic             cpu_irq
);
    import irq_gather_pkg::*;

    localparam int HID_W = SRC_W - VIS_W;

    logic [SRC_W-1:0] pend_q;
    logic [VIS_W-1:0] en_q;

    irq_pending_reg #(.SRC_W(SRC_W)) u_pending (
        .clk       (clk),
        .rst_n     (rst_n),
        .raise_vec (raise_vec),
        .drop_vec  (drop_vec),
        .pend_q    (pend_q)
    );

    irq_mask_reg #(.VIS_W(VIS_W)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .en_q      (en_q)
    );

    irq_line_gen #(.SRC_W(SRC_W), .VIS_W(VIS_W)) u_line (
        .pend_q  (pend_q),
        .en_q    (en_q),
        .cpu_irq (cpu_irq)
    );

    // Only the visible window of the pending vector reaches the read path.
    always_comb begin
        if (!reg_sel) begin
            reg_rdata = '0;
        end else begin
            unique case (reg_sel_e'(reg_addr))
                SEL_MASK:    reg_rdata = en_q;
                SEL_PENDING: reg_rdata = pend_q[VIS_W-1:0];
            endcase
        end
    end

    assert_hidden_drives_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_q[SRC_W-1:SRC_W-HID_W]) |-> cpu_irq);

    assert_quiet_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == '0) |-> !cpu_irq);

    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0 && pend_q[SRC_W-1:VIS_W] == '0) |-> !cpu_irq);
endmodule

// File: tb/test_irq_gather.sv
module test_irq_gather;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] raise_vec = '0;
    logic [11:0] drop_vec = '0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        cpu_irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    irq_gather i_irq_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .raise_vec (raise_vec),
        .drop_vec  (drop_vec),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cpu_irq   (cpu_irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected under 5000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Read both registers between edges; reads have no side effect.
    task automatic read_regs(output logic [7:0] en_rd, output logic [7:0] pl_rd);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = 1'b0;
        #1 en_rd = reg_rdata;
        reg_addr = 1'b1;
        #1 pl_rd = reg_rdata;
        reg_sel = 1'b0; reg_addr = 1'b0;
    endtask

    task automatic step(input logic [11:0] r, input logic [11:0] d,
                        input logic s, input logic w, input logic a, input logic [7:0] wd);
        @(negedge clk);
        raise_vec = r; drop_vec = d;
        reg_sel = s; reg_wr = w; reg_addr = a; reg_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        raise_vec = '0; drop_vec = '0;
        reg_sel = 1'b0; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    endtask

    // {raise, drop, wr, addr, wdata, exp_mask, exp_pend_low, exp_irq}
    localparam int NV = 14;
    localparam logic [50:0] VEC [NV] = '{
        {12'h001, 12'h000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h01, 1'b0}, // R2 R9 masked pending
        {12'h000, 12'h000, 1'b1, 1'b0, 8'h01, 8'h01, 8'h01, 1'b1}, // R5 R9 enable raises line
        {12'h0F0, 12'h000, 1'b0, 1'b0, 8'h00, 8'h01, 8'hF1, 1'b1}, // R2
        {12'h000, 12'h001, 1'b0, 1'b0, 8'h00, 8'h01, 8'hF0, 1'b0}, // R3 R7
        {12'h000, 12'h000, 1'b1, 1'b0, 8'h30, 8'h30, 8'hF0, 1'b1}, // R5 R7
        {12'h000, 12'h000, 1'b1, 1'b1, 8'hFF, 8'h30, 8'hF0, 1'b1}, // R6 write to pending ignored
        {12'h100, 12'h0F0, 1'b0, 1'b0, 8'h00, 8'h30, 8'h00, 1'b1}, // R8 hidden only
        {12'h000, 12'h000, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 1'b1}, // R8 unmaskable
        {12'h002, 12'h102, 1'b0, 1'b0, 8'h00, 8'h00, 8'h02, 1'b0}, // R4 raise wins
        {12'h000, 12'h002, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0}, // R3
        {12'h800, 12'h000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b1}, // R8 top hidden bit
        {12'h000, 12'h800, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0}, // R7 line drops
        {12'h0AA, 12'h000, 1'b1, 1'b0, 8'hFF, 8'hFF, 8'hAA, 1'b1}, // R2 R5
        {12'h000, 12'h0AA, 1'b0, 1'b0, 8'h00, 8'hFF, 8'h00, 1'b0}  // R3 R7
    };

    initial begin
        logic [7:0] en_rd;
        logic [7:0] pl_rd;

        #5;
        check("R1 irq in reset", {11'h0, cpu_irq}, 12'h0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_regs(en_rd, pl_rd);
        check("R1 mask after reset", {4'h0, en_rd}, 12'h000);
        check("R1 pending after reset", {4'h0, pl_rd}, 12'h000);
        check("R1 irq after reset", {11'h0, cpu_irq}, 12'h0);

        for (int k = 0; k < NV; k++) begin
            step(VEC[k][50:39], VEC[k][38:27], VEC[k][26], VEC[k][26], VEC[k][25], VEC[k][24:17]);
            read_regs(en_rd, pl_rd);
            check($sformatf("R5 R6 vec %0d mask", k), {4'h0, en_rd}, {4'h0, VEC[k][16:9]});
            check($sformatf("R2 R3 R6 vec %0d pending", k), {4'h0, pl_rd}, {4'h0, VEC[k][8:1]});
            check($sformatf("R7 R8 vec %0d irq", k), {11'h0, cpu_irq}, {11'h0, VEC[k][0]});
        end

        // R10: write strobe without select is ignored (mask is 0xFF, pending 0)
        step(12'h000, 12'h000, 1'b0, 1'b1, 1'b0, 8'h55);
        read_regs(en_rd, pl_rd);
        check("R10 mask unchanged", {4'h0, en_rd}, 12'h0FF);

        // R6: read data is zero when not selected
        reg_sel = 1'b0; reg_addr = 1'b0;
        #1 check("R6 rdata without select", {4'h0, reg_rdata}, 12'h000);

        // R8: hidden bit read shows zero in the hidden window; low byte visible
        step(12'h203, 12'h000, 1'b0, 1'b0, 1'b0, 8'h00);
        read_regs(en_rd, pl_rd);
        check("R8 pending read low byte only", {4'h0, pl_rd}, 12'h003);
        check("R8 irq with hidden", {11'h0, cpu_irq}, 12'h1);

        // R1: reset mid-run clears mask and all pending, hidden included
        @(negedge clk);
        rst_n = 1'b0;
        #1 check("R1 irq drops in reset", {11'h0, cpu_irq}, 12'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_regs(en_rd, pl_rd);
        check("R1 mask cleared", {4'h0, en_rd}, 12'h000);
        check("R1 pending cleared", {4'h0, pl_rd}, 12'h000);
        check("R1 hidden cleared, irq low", {11'h0, cpu_irq}, 12'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule